// File: doc/BRIEF.md
# Mailbox Message Request Sequencer

This block is a bus master that hands one command at a time to a power-management microcontroller through three mailbox registers: the message register, the argument register and the response register. A requester supplies a message code, a 32-bit argument, an argument-format selector and a flag that asks for a returned value. The sequencer first waits for any earlier transaction to finish by polling the response register. It then clears the response register, loads the argument and writes the message code, and that last write starts the transaction. It polls the response register again until a reply appears or the retry budget runs out.

Polls are spaced a fixed number of clock cycles apart, and each wait allows a bounded number of extra reads. The outcome is one pulse carrying pass, timeout and a 32-bit result. When the reply equals the OK code and the requester asked for a value, the result is the argument register read back after the reply. Two argument packers are built in. One forms a clock hard-minimum request from a clock identifier and a frequency in MHz. The other forms a cache-way count word with an enable bit in bit 0.

Top module: `mbox_req_seq`

## Requirements
- R1: `req_ready` is 1 only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle in which `done` pulses.
- R2: After accepting a request, the sequencer reads the response register (address `RESP_ADDR`, default 0x16274) until a read returns non-zero or `MAX_RETRY`+1 reads have been made. It then continues with the send whatever that wait returned.
- R3: The send consists of three writes on consecutive cycles, in this order: 0 to `RESP_ADDR`, the packed argument to `ARG_ADDR` (default 0x16273), then the message code to `MSG_ADDR` (default 0x1628A).
- R4: After the message write, the sequencer reads the response register until the first non-zero value and then stops reading it. The first read follows the message write by exactly one cycle. The first read of the pre-wait follows acceptance by one cycle.
- R5: Within one wait, two consecutive response reads start exactly `POLL_GAP` cycles apart (`POLL_GAP` ≥ 3). A wait never makes more than `MAX_RETRY`+1 reads.
- R6: When the final response equals `OK_CODE` (default 1), `pass`=1 and `timeout`=0. When it is any other non-zero value, `pass`=0 and `timeout`=0.
- R7: When the post-send wait uses up its reads with every read returning zero, the sequencer ends with `pass`=0, `timeout`=1 and `result`=0.
- R8: When the response is OK and `req_want`=1, the sequencer makes exactly one further read, of `ARG_ADDR`, and `result` is the data returned. In every other case that read is not made and `result`=0.
- R9: With `req_fmt`=1 (clock hard-minimum), the argument written is bits 23:16 of `req_arg` (clock identifier) in bits 23:16, bits 15:0 of `req_arg` (frequency in MHz) in bits 15:0, and zero in bits 31:24.
- R10: With `req_fmt`=2 (cache ways), the argument written is `req_arg[30:0]` shifted left by one bit, with bit 0 set exactly when that count is non-zero.
- R11: With `req_fmt`=0 or 3, `req_arg` is written unchanged.
- R12: `done` is a single-cycle pulse. It is high in the cycle after the last check of the response (or of the result read), and `req_ready` is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_msg | input | MSG_W | Message code written last |
| req_arg | input | DATA_W | Raw argument |
| req_fmt | input | 2 | Argument packing: 0 raw, 1 clock hard-min, 2 cache ways, 3 raw |
| req_want | input | 1 | Return the argument register after success |
| bus_valid | output | 1 | Bus access this cycle |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid one cycle after a read |
| done | output | 1 | Completion pulse |
| pass | output | 1 | Response equalled the OK code |
| timeout | output | 1 | Post-send wait ran out of reads |
| result | output | DATA_W | Returned value, 0 when not returned |

## Verification
The responder model returns a chosen number of zero reads before each reply. This tries the pre-wait with an immediate reply, with a reply after a few polls, and with no reply within the budget, which shows that the send goes ahead in every case. After the send it varies the reply between the OK code, a non-OK non-zero code and a permanent zero, which separates pass, plain failure and timeout. Raw, hard-minimum and way-count arguments, including a zero way count, separate the packers. Runs with `req_want` on and off show when the result read is made.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_RD,
    ST_POLL_CHK,
    ST_POLL_WAIT,
    ST_WR_CLR,
    ST_WR_ARG,
    ST_WR_MSG,
    ST_RES_RD,
    ST_RES_CHK
  } seq_st_e;

  localparam logic [1:0] FMT_RAW     = 2'd0;
  localparam logic [1:0] FMT_HARDMIN = 2'd1;
  localparam logic [1:0] FMT_WAYS    = 2'd2;

endpackage

// File: rtl/mbox_arg_pack.sv
module mbox_arg_pack
  import mbox_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CLKID_W = 8,
  parameter int FREQ_W  = 16
) (
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] packed_arg
);

  localparam int ID_LO = FREQ_W;
  localparam int ID_HI = FREQ_W + CLKID_W - 1;

  logic [DATA_W-2:0] ways;
  assign ways = raw[DATA_W-2:0];

  always_comb begin
    packed_arg = raw;
    case (fmt)
      FMT_HARDMIN: begin
        packed_arg              = '0;
        packed_arg[ID_HI:ID_LO] = raw[ID_HI:ID_LO];
        packed_arg[FREQ_W-1:0]  = raw[FREQ_W-1:0];
      end
      FMT_WAYS: packed_arg = {ways, (ways != '0)};
      default:  packed_arg = raw;
    endcase
  end

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int POLL_GAP = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);

  localparam int CNT_W = $clog2(POLL_GAP + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(POLL_GAP - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt <= CNT_W'(1));

endmodule

// File: rtl/mbox_retry_ctr.sv
module mbox_retry_ctr #(
  parameter int MAX_RETRY = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic exhausted
);

  localparam int CNT_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (inc && !exhausted) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign exhausted = (cnt == CNT_W'(MAX_RETRY));

endmodule

// File: rtl/mbox_req_seq.sv
module mbox_req_seq
  import mbox_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 32,
  parameter int              MSG_W     = 32,
  parameter int              CLK_MHZ   = 100,
  parameter int              POLL_US   = 10,
  parameter int              POLL_GAP  = CLK_MHZ * POLL_US,
  parameter int              MAX_RETRY = 200000,
  parameter logic [DATA_W-1:0] OK_CODE = 1,
  parameter logic [ADDR_W-1:0] MSG_ADDR  = 20'h1628A,
  parameter logic [ADDR_W-1:0] ARG_ADDR  = 20'h16273,
  parameter logic [ADDR_W-1:0] RESP_ADDR = 20'h16274
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MSG_W-1:0]  req_msg,
  input  logic [DATA_W-1:0] req_arg,
  input  logic [1:0]        req_fmt,
  input  logic              req_want,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic              pass,
  output logic              timeout,
  output logic [DATA_W-1:0] result
);

  seq_st_e           st;
  logic              post_q;
  logic [MSG_W-1:0]  msg_q;
  logic [DATA_W-1:0] arg_q;
  logic              want_q;
  logic [DATA_W-1:0] packed_arg;
  logic              gap_expire;
  logic              retry_done;
  logic              accept;
  logic              retry_clr;
  logic              retry_inc;
  logic              resp_seen;
  logic              resp_ok;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign resp_seen = (bus_rdata != '0);
  assign resp_ok   = (bus_rdata == OK_CODE);
  assign retry_clr = accept || (st == ST_WR_MSG);
  assign retry_inc = (st == ST_POLL_CHK) && !resp_seen && !retry_done;

  mbox_arg_pack #(.DATA_W(DATA_W)) u_pack (
    .fmt       (req_fmt),
    .raw       (req_arg),
    .packed_arg(packed_arg)
  );

  mbox_poll_timer #(.POLL_GAP(POLL_GAP)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (st == ST_POLL_RD),
    .expire(gap_expire)
  );

  mbox_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .clear    (retry_clr),
    .inc      (retry_inc),
    .exhausted(retry_done)
  );

  // Bus decode from the state register
  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = RESP_ADDR;
    bus_wdata = '0;
    case (st)
      ST_POLL_RD: begin
        bus_valid = 1'b1;
      end
      ST_WR_CLR: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
      end
      ST_WR_ARG: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = ARG_ADDR;
        bus_wdata = arg_q;
      end
      ST_WR_MSG: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = MSG_ADDR;
        bus_wdata = DATA_W'(msg_q);
      end
      ST_RES_RD: begin
        bus_valid = 1'b1;
        bus_addr  = ARG_ADDR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      post_q  <= 1'b0;
      msg_q   <= '0;
      arg_q   <= '0;
      want_q  <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
      timeout <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            msg_q  <= req_msg;
            arg_q  <= packed_arg;
            want_q <= req_want;
            post_q <= 1'b0;
            st     <= ST_POLL_RD;
          end
        end
        ST_POLL_RD:   st <= ST_POLL_CHK;
        ST_POLL_CHK: begin
          if (resp_seen || retry_done) begin
            if (!post_q) begin
              st <= ST_WR_CLR;
            end else if (resp_ok && want_q) begin
              st <= ST_RES_RD;
            end else begin
              done    <= 1'b1;
              pass    <= resp_ok;
              timeout <= !resp_seen;
              result  <= '0;
              st      <= ST_IDLE;
            end
          end else begin
            st <= ST_POLL_WAIT;
          end
        end
        ST_POLL_WAIT: if (gap_expire) st <= ST_POLL_RD;
        ST_WR_CLR:    st <= ST_WR_ARG;
        ST_WR_ARG:    st <= ST_WR_MSG;
        ST_WR_MSG: begin
          post_q <= 1'b1;
          st     <= ST_POLL_RD;
        end
        ST_RES_RD:    st <= ST_RES_CHK;
        ST_RES_CHK: begin
          done    <= 1'b1;
          pass    <= 1'b1;
          timeout <= 1'b0;
          result  <= bus_rdata;
          st      <= ST_IDLE;
        end
        default:      st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbox_req_seq_chk.sv
module mbox_req_seq_chk #(
  parameter int              ADDR_W    = 20,
  parameter int              DATA_W    = 32,
  parameter int              POLL_GAP  = 1000,
  parameter int              MAX_RETRY = 200000,
  parameter logic [ADDR_W-1:0] MSG_ADDR  = 20'h1628A,
  parameter logic [ADDR_W-1:0] ARG_ADDR  = 20'h16273,
  parameter logic [ADDR_W-1:0] RESP_ADDR = 20'h16274
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              done,
  input logic              pass,
  input logic              timeout,
  input logic [DATA_W-1:0] result
);

  logic resp_rd;
  logic any_wr;
  logic seen_rd;
  int   gap_cnt;
  int   rd_cnt;

  assign resp_rd = bus_valid && !bus_write && (bus_addr == RESP_ADDR);
  assign any_wr  = bus_valid && bus_write;

  always_ff @(posedge clk) begin
    if (rst || any_wr || done) begin
      seen_rd <= 1'b0;
      gap_cnt <= 0;
      rd_cnt  <= 0;
    end else if (resp_rd) begin
      seen_rd <= 1'b1;
      gap_cnt <= 1;
      rd_cnt  <= rd_cnt + 1;
    end else if (gap_cnt < POLL_GAP + 1) begin
      gap_cnt <= gap_cnt + 1;
    end
  end

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_arg_after_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (any_wr && bus_addr == ARG_ADDR) |->
      $past(any_wr && bus_addr == RESP_ADDR && bus_wdata == '0));

  assert_msg_after_arg_R3: assert property (@(posedge clk) disable iff (rst)
    (any_wr && bus_addr == MSG_ADDR) |-> $past(any_wr && bus_addr == ARG_ADDR));

  assert_poll_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    (resp_rd && seen_rd) |-> (gap_cnt == POLL_GAP));

  assert_poll_budget_R5: assert property (@(posedge clk) disable iff (rst)
    resp_rd |-> (rd_cnt <= MAX_RETRY));

  assert_read_single_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> !bus_valid);

  assert_ok_not_timeout_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !(pass && timeout));

  assert_fail_zero_result_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !pass) |-> (result == '0));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind mbox_req_seq mbox_req_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .POLL_GAP (POLL_GAP),
  .MAX_RETRY(MAX_RETRY),
  .MSG_ADDR (MSG_ADDR),
  .ARG_ADDR (ARG_ADDR),
  .RESP_ADDR(RESP_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .done     (done),
  .pass     (pass),
  .timeout  (timeout),
  .result   (result)
);

// File: tb/mbox_req_seq_tb_top.sv
module mbox_req_seq_tb_top;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int GAP    = 4;
  localparam int MAXR   = 3;
  localparam logic [ADDR_W-1:0] A_MSG  = 20'h1628A;
  localparam logic [ADDR_W-1:0] A_ARG  = 20'h16273;
  localparam logic [ADDR_W-1:0] A_RESP = 20'h16274;

  typedef struct packed {
    int                cyc;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } op_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [31:0]       req_msg = '0;
  logic [DATA_W-1:0] req_arg = '0;
  logic [1:0]        req_fmt = '0;
  logic              req_want = 1'b0;
  logic              bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              done, pass, timeout;
  logic [DATA_W-1:0] result;

  int  cyc = 0;
  int  n_tests = 0;
  int  n_fail = 0;
  op_t exp_q[$];

  // responder configuration, set by the stimulus
  logic              rsp_load = 1'b0;
  int                cfg_pre_zero = 0;
  logic [DATA_W-1:0] cfg_prev = '0;
  int                cfg_post_zero = 0;
  logic [DATA_W-1:0] cfg_code = '0;
  logic [DATA_W-1:0] cfg_ret = '0;

  int                zr;
  logic [DATA_W-1:0] resp_val;
  logic [DATA_W-1:0] arg_reg;

  always #5 clk = ~clk;

  mbox_req_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_GAP(GAP), .MAX_RETRY(MAXR)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_msg(req_msg), .req_arg(req_arg), .req_fmt(req_fmt), .req_want(req_want),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done), .pass(pass),
    .timeout(timeout), .result(result)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural mailbox responder
  always @(posedge clk) begin
    if (rsp_load) begin
      zr       <= cfg_pre_zero;
      resp_val <= cfg_prev;
      arg_reg  <= '0;
    end else if (bus_valid && bus_write) begin
      if (bus_addr == A_RESP) resp_val <= bus_wdata;
      if (bus_addr == A_ARG)  arg_reg  <= bus_wdata;
      if (bus_addr == A_MSG) begin
        zr       <= cfg_post_zero;
        resp_val <= cfg_code;
        arg_reg  <= cfg_ret;
      end
    end else if (bus_valid) begin
      if (bus_addr == A_RESP) begin
        if (zr > 0) begin
          bus_rdata <= '0;
          zr        <= zr - 1;
        end else begin
          bus_rdata <= resp_val;
        end
      end else if (bus_addr == A_ARG) begin
        bus_rdata <= arg_reg;
      end else begin
        bus_rdata <= '0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // every bus access is compared against the expected timeline
  always @(negedge clk) begin
    if (!rst && bus_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected bus access", {44'd0, bus_addr}, 64'd0);
      end else begin
        op_t e;
        e = exp_q.pop_front();
        chk(cyc == e.cyc, "R5 access cycle", 64'(cyc), 64'(e.cyc));
        chk(bus_write == e.wr && bus_addr == e.addr, "R3 access kind/address",
            {43'd0, bus_write, bus_addr}, {43'd0, e.wr, e.addr});
        if (e.wr)
          chk(bus_wdata == e.data, "R3 write data", 64'(bus_wdata), 64'(e.data));
      end
    end
  end

  function automatic logic [DATA_W-1:0] ref_pack(input logic [1:0] f,
                                                 input logic [DATA_W-1:0] a);
    if (f == 2'd1) return {8'h00, a[23:16], a[15:0]};
    if (f == 2'd2) return {a[30:0], (a[30:0] != 0)};
    return a;
  endfunction

  task automatic run_case(input string name, input logic [1:0] fmt,
                          input logic [DATA_W-1:0] arg, input logic [31:0] msg,
                          input bit want, input int pre_zero, input logic [DATA_W-1:0] prev,
                          input int post_zero, input logic [DATA_W-1:0] code,
                          input logic [DATA_W-1:0] ret, input logic [DATA_W-1:0] exp_arg);
    int x, n_pre, n_post, l1, l2, done_cyc, waited;
    logic [DATA_W-1:0] fin, exp_res;
    bit exp_pass, exp_to;
    op_t o;
    @(negedge clk);
    cfg_pre_zero = pre_zero; cfg_prev = prev; cfg_post_zero = post_zero;
    cfg_code = code; cfg_ret = ret; rsp_load = 1'b1;
    @(negedge clk);
    rsp_load = 1'b0;
    chk(ref_pack(fmt, arg) == exp_arg, {name, " R9 R10 R11 packer reference"},
        64'(ref_pack(fmt, arg)), 64'(exp_arg));
    x      = cyc;
    n_pre  = (pre_zero > MAXR) ? MAXR + 1 : pre_zero + 1;
    l1     = x + 1 + (n_pre - 1) * GAP;
    for (int i = 0; i < n_pre; i++) begin
      o = '{cyc: x + 1 + i * GAP, wr: 1'b0, addr: A_RESP, data: '0}; exp_q.push_back(o);
    end
    o = '{cyc: l1 + 2, wr: 1'b1, addr: A_RESP, data: '0};     exp_q.push_back(o);
    o = '{cyc: l1 + 3, wr: 1'b1, addr: A_ARG,  data: exp_arg}; exp_q.push_back(o);
    o = '{cyc: l1 + 4, wr: 1'b1, addr: A_MSG,  data: msg};     exp_q.push_back(o);
    n_post = (post_zero > MAXR) ? MAXR + 1 : post_zero + 1;
    for (int i = 0; i < n_post; i++) begin
      o = '{cyc: l1 + 5 + i * GAP, wr: 1'b0, addr: A_RESP, data: '0}; exp_q.push_back(o);
    end
    l2       = l1 + 5 + (n_post - 1) * GAP;
    fin      = (post_zero > MAXR) ? '0 : code;
    exp_pass = (fin == 1);
    exp_to   = (fin == 0);
    exp_res  = '0;
    done_cyc = l2 + 2;
    if (exp_pass && want) begin
      o = '{cyc: l2 + 2, wr: 1'b0, addr: A_ARG, data: '0}; exp_q.push_back(o);
      exp_res  = ret;
      done_cyc = l2 + 4;
    end
    req_fmt = fmt; req_arg = arg; req_msg = msg; req_want = want;
    chk(req_ready == 1'b1, {name, " R1 ready while idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {name, " R1 busy after accept"}, 64'(req_ready), 64'd0);
    waited = 0;
    while (!done && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    chk(cyc == done_cyc, {name, " R12 done cycle"}, 64'(cyc), 64'(done_cyc));
    chk(pass == exp_pass, {name, " R6 pass"}, 64'(pass), 64'(exp_pass));
    chk(timeout == exp_to, {name, " R7 timeout"}, 64'(timeout), 64'(exp_to));
    chk(result == exp_res, {name, " R8 result"}, 64'(result), 64'(exp_res));
    chk(req_ready == 1'b1, {name, " R12 ready with done"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, {name, " R12 single pulse"}, 64'(done), 64'd0);
    chk(exp_q.size() == 0, {name, " R2 R4 all accesses made"}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && bus_valid == 1'b0, "R1 reset state",
        {61'd0, req_ready, done, bus_valid}, 64'h4);
    // R4 R6 R8: raw argument, reply after two polls, value returned
    run_case("raw_ok_want", 2'd0, 32'h1234_5678, 32'h0000_0011, 1'b1,
             0, 32'h1, 2, 32'h1, 32'hCAFE_0001, 32'h1234_5678);
    // R2 R9: pre-wait needs two polls, clock hard-min packing
    run_case("hardmin", 2'd1, 32'hFF12_0640, 32'h0000_001A, 1'b1,
             2, 32'h1, 0, 32'h1, 32'h0000_0640, 32'h0012_0640);
    // R10 R8: way count 5, no value asked for
    run_case("ways5", 2'd2, 32'h0000_0005, 32'h0000_0030, 1'b0,
             0, 32'h1, 1, 32'h1, 32'h5555_AAAA, 32'h0000_000B);
    // R10: zero way count keeps bit 0 clear
    run_case("ways0", 2'd2, 32'h0000_0000, 32'h0000_0030, 1'b0,
             0, 32'h1, 0, 32'h1, 32'h0, 32'h0000_0000);
    // R6 R8: non-OK non-zero reply, no result read despite request
    run_case("bad_code", 2'd0, 32'h0000_00FF, 32'h0000_0005, 1'b1,
             0, 32'h1, 1, 32'h3, 32'hDEAD_BEEF, 32'h0000_00FF);
    // R7 R5: reply never arrives within the budget
    run_case("post_timeout", 2'd0, 32'h0000_0001, 32'h0000_0007, 1'b1,
             0, 32'h1, 10, 32'h1, 32'h7777_7777, 32'h0000_0001);
    // R2 R11: pre-wait exhausts its budget yet the send proceeds, fmt 3 is raw
    run_case("pre_timeout", 2'd3, 32'h8000_0002, 32'h0000_0009, 1'b1,
             10, 32'h1, 0, 32'h1, 32'h0000_4242, 32'h8000_0002);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule